// File: doc/BRIEF.md
# Transmit Command Word Parser

This block sits behind a host write port that carries a transmit stream as 32-bit words. Every buffer the host hands over begins with a first command word giving the byte count, a leading byte offset, segment markers, an end-alignment mode and a completion-interrupt request. A buffer that opens a frame carries a second command word whose upper half is a host tag. The payload words that follow have the leading offset bytes and any trailing alignment pad words stripped away, and the remaining payload bytes are appended to a frame store. Several segments can build one frame.

When the buffer marked as the last segment is fully consumed, the block pulses a frame-done strobe together with the frame byte length, and pushes the frame's tag into a status FIFO that the host drains later. A bounded count of words held for the current frame models the data FIFO. A write that arrives when this count is at capacity is dropped and flagged. A clear input returns the parser to its command-expecting state.

Top module: `txcmd_parser`

## Requirements
- R1: After reset, frame_done, done_irq, ovf_irq and stat_full_irq are low, stat_empty is high and stat_level is zero.
- R2: In the idle state the accepted word is the first command word: bits 10:0 give the buffer byte count, bits 20:16 the leading offset, bit 13 marks the first segment, bit 12 the last segment, bit 31 requests a completion interrupt and bits 25:24 select end alignment.
- R3: The next accepted word is the second command word. When the first-segment bit is set, its bits 31:16 become the frame tag and the frame length returns to zero. Otherwise the word is consumed and discarded.
- R4: While the remaining offset is 4 or more, each payload word is discarded and the offset drops by 4. The next word then skips its (offset mod 4) least significant bytes.
- R5: Payload bytes are taken least significant byte first and stored at consecutive addresses starting at the current frame length. A word's bytes that lie beyond the buffer's byte count are not stored.
- R6: On a first segment with alignment mode 1 (or 2), pad words bring ceil((count + offset) / 4) up to a multiple of 4 (or 8). Pad words follow the payload, are consumed and are not stored. Other segments and modes carry no pad.
- R7: When a last-segment buffer ends, frame_done is high for exactly the cycle after the final word, frame_len holds the frame's total stored byte count, and the tag is pushed into the status FIFO (read head on stat_tag, removed by stat_pop).
- R8: A tag that arrives while the status FIFO holds STAT_DEPTH entries is dropped, and stat_full_irq pulses in the cycle after.
- R9: When any buffer whose first command word had bit 31 set ends, done_irq pulses in the cycle after its final word.
- R10: The data FIFO count rises with each accepted first command word, first-segment second command word and payload word that carries bytes, and returns to zero when a frame is sent. A write while it equals DFIFO_WORDS is ignored, and ovf_irq pulses in the cycle after.
- R11: The frame store holds FRAME_BYTES bytes. Bytes addressed beyond it are discarded, and frame_len stops at FRAME_BYTES.
- R12: clr returns the parser to the idle state and zeroes the data FIFO count, but keeps the frame length. A word written in the same cycle as clr is ignored.
- R13: A segment without the first-segment bit appends its bytes after those already in the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host word write strobe |
| wr_data | input | 32 | Host word |
| clr | input | 1 | Parser clear |
| frame_done | output | 1 | One-cycle frame sent strobe |
| frame_len | output | LEN_W | Bytes stored in the current frame |
| rd_addr | input | ADDR_W | Frame store read address |
| rd_data | output | 8 | Frame store byte at rd_addr |
| done_irq | output | 1 | Buffer completion interrupt pulse |
| ovf_irq | output | 1 | Data FIFO overflow pulse |
| stat_full_irq | output | 1 | Status FIFO drop pulse |
| stat_pop | input | 1 | Remove status FIFO head |
| stat_tag | output | 16 | Status FIFO head tag |
| stat_empty | output | 1 | Status FIFO empty |
| stat_level | output | LVL_W | Status FIFO entry count |

## Verification
The embedded properties assume that stat_pop is raised only while the status FIFO holds an entry, and that clr and wr_en are synchronous to clk and are never left undriven after reset. The stimulus keeps to this. Every pop is issued only after a tag has been seen on stat_tag. clr is a single-cycle pulse, driven away from the edge like every other input, and it is also used once together with a write to exercise the priority case.

// File: rtl/txp_pkg.sv
package txp_pkg;
   typedef enum logic [1:0] {ST_CMDA, ST_CMDB, ST_DATA} txp_state_e;

   // Pad words that round the payload word count up to the aligned boundary.
   function automatic logic [2:0] pad_words(input logic [10:0] bytes,
                                            input logic [4:0]  skew,
                                            input logic [1:0]  mode);
      logic [12:0] words;
      logic [12:0] neg;
      words = (13'(bytes) + 13'(skew) + 13'd3) >> 2;
      neg   = ~words + 13'd1;
      case (mode)
         2'd1:    pad_words = {1'b0, neg[1:0]};
         2'd2:    pad_words = neg[2:0];
         default: pad_words = 3'd0;
      endcase
   endfunction
endpackage

// File: rtl/txp_tag_fifo.sv
module txp_tag_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 512,
   localparam int PW   = $clog2(DEPTH),
   localparam int LW   = $clog2(DEPTH) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic          empty,
   output logic [LW-1:0] level,
   output logic          drop
);
   generate
      if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth
         $error("txp_tag_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp;
   logic          full, do_push, do_pop;

   assign full    = (level == LW'(DEPTH));
   assign empty   = (level == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
         drop  <= 1'b0;
      end else begin
         drop <= push && full;
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         level <= level + LW'(do_push) - LW'(do_pop);
      end
   end

   assert_level_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LW'(DEPTH));
   assert_drop_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
      drop |-> $past(level) == LW'(DEPTH));
endmodule

// File: rtl/txp_frame_store.sv
module txp_frame_store #(
   parameter int DEPTH = 2048,
   localparam int AW   = $clog2(DEPTH),
   localparam int LW   = $clog2(DEPTH) + 1
) (
   input  logic          clk,
   input  logic          wr,
   input  logic [LW-1:0] base,
   input  logic [31:0]   word,
   input  logic [1:0]    shift,
   input  logic [2:0]    take,
   output logic [2:0]    stored,
   input  logic [AW-1:0] rd_addr,
   output logic [7:0]    rd_data
);
   logic [7:0]    mem [DEPTH];
   logic [31:0]   aligned;
   logic [3:0]    lane_ok;
   logic [LW:0]   lane_addr [4];
   logic [7:0]    lane_byte [4];

   assign aligned = word >> {shift, 3'b000};

   for (genvar k = 0; k < 4; k++) begin : g_lane
      assign lane_addr[k] = {1'b0, base} + (LW+1)'(k);
      assign lane_byte[k] = aligned[8*k +: 8];
      assign lane_ok[k]   = (3'(k) < take) && (lane_addr[k] < (LW+1)'(DEPTH));
   end

   assign stored  = 3'($countones(lane_ok));
   assign rd_data = mem[rd_addr];

   always_ff @(posedge clk) begin
      for (int k = 0; k < 4; k++) begin
         if (wr && lane_ok[k]) mem[lane_addr[k][AW-1:0]] <= lane_byte[k];
      end
   end
endmodule

// File: rtl/txcmd_parser.sv
module txcmd_parser
   import txp_pkg::*;
#(
   parameter int FRAME_BYTES = 2048,
   parameter int DFIFO_WORDS = 1152,
   parameter int STAT_DEPTH  = 512,
   localparam int LEN_W  = $clog2(FRAME_BYTES) + 1,
   localparam int ADDR_W = $clog2(FRAME_BYTES),
   localparam int LVL_W  = $clog2(STAT_DEPTH) + 1,
   localparam int USED_W = $clog2(DFIFO_WORDS + 1),
   localparam int TAG_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [31:0]       wr_data,
   input  logic              clr,
   output logic              frame_done,
   output logic [LEN_W-1:0]  frame_len,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   output logic              done_irq,
   output logic              ovf_irq,
   output logic              stat_full_irq,
   input  logic              stat_pop,
   output logic [TAG_W-1:0]  stat_tag,
   output logic              stat_empty,
   output logic [LVL_W-1:0]  stat_level
);
   generate
      if (FRAME_BYTES < 4 || FRAME_BYTES > 2048) begin : g_bad_frame
         $error("txcmd_parser: FRAME_BYTES must lie in 4..2048");
      end
      if (DFIFO_WORDS < 3) begin : g_bad_dfifo
         $error("txcmd_parser: DFIFO_WORDS must be at least 3");
      end
   endgenerate

   txp_state_e        st_q, st_d;
   logic [USED_W-1:0] used_q, used_d;
   logic [10:0]       rem_q, rem_d;
   logic [4:0]        off_q, off_d;
   logic [2:0]        pad_q, pad_d;
   logic [LEN_W-1:0]  len_q, len_d;
   logic [TAG_W-1:0]  tag_q, tag_d;
   logic              first_q, first_d, last_q, last_d, ioc_q, ioc_d;
   logic [1:0]        mode_q, mode_d;
   logic              done_d, irq_d, push, st_wr, fin;
   logic              full, accept;
   logic [2:0]        take_max, take, stored;

   assign full     = (used_q == USED_W'(DFIFO_WORDS));
   assign accept   = wr_en && !clr && !full;
   assign take_max = 3'd4 - {1'b0, off_q[1:0]};
   assign take     = (rem_q < 11'(take_max)) ? rem_q[2:0] : take_max;

   always_comb begin
      st_d = st_q;   used_d = used_q; rem_d = rem_q;   off_d = off_q;
      pad_d = pad_q; len_d = len_q;   tag_d = tag_q;   first_d = first_q;
      last_d = last_q; ioc_d = ioc_q; mode_d = mode_q;
      done_d = 1'b0; irq_d = 1'b0; push = 1'b0; st_wr = 1'b0; fin = 1'b0;
      case (st_q)
         ST_CMDA: if (accept) begin
            first_d = wr_data[13];
            last_d  = wr_data[12];
            ioc_d   = wr_data[31];
            mode_d  = wr_data[25:24];
            rem_d   = wr_data[10:0];
            off_d   = wr_data[20:16];
            used_d  = used_q + 1'b1;
            st_d    = ST_CMDB;
         end
         ST_CMDB: if (accept) begin
            st_d = ST_DATA;
            if (first_q) begin
               tag_d  = wr_data[31:16];
               used_d = used_q + 1'b1;
               len_d  = '0;
               pad_d  = pad_words(rem_q, off_q, mode_q);
            end else begin
               pad_d = '0;
            end
         end
         ST_DATA: if (accept) begin
            if (off_q >= 5'd4) begin
               off_d = off_q - 5'd4;
            end else begin
               if (rem_q == '0 && pad_q != '0) begin
                  pad_d = pad_q - 1'b1;
               end else begin
                  st_wr  = 1'b1;
                  rem_d  = rem_q - 11'(take);
                  off_d  = '0;
                  len_d  = len_q + LEN_W'(stored);
                  used_d = used_q + 1'b1;
               end
               fin = (rem_d == '0) && (pad_d == '0);
            end
            if (fin) begin
               st_d  = ST_CMDA;
               irq_d = ioc_q;
               if (last_q) begin
                  done_d = 1'b1;
                  push   = 1'b1;
                  used_d = '0;
               end
            end
         end
         default: st_d = ST_CMDA;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_CMDA; used_q <= '0; rem_q <= '0; off_q <= '0;
         pad_q <= '0; len_q <= '0; tag_q <= '0; first_q <= 1'b0;
         last_q <= 1'b0; ioc_q <= 1'b0; mode_q <= '0;
         frame_done <= 1'b0; done_irq <= 1'b0; ovf_irq <= 1'b0;
      end else begin
         rem_q <= rem_d; off_q <= off_d; pad_q <= pad_d; len_q <= len_d;
         tag_q <= tag_d; first_q <= first_d; last_q <= last_d;
         ioc_q <= ioc_d; mode_q <= mode_d;
         frame_done <= done_d;
         done_irq   <= irq_d;
         ovf_irq    <= wr_en && !clr && full;
         if (clr) begin
            st_q   <= ST_CMDA;
            used_q <= '0;
         end else begin
            st_q   <= st_d;
            used_q <= used_d;
         end
      end
   end

   assign frame_len = len_q;

   txp_frame_store #(.DEPTH(FRAME_BYTES)) u_store (
      .clk(clk), .wr(st_wr), .base(len_q), .word(wr_data), .shift(off_q[1:0]),
      .take(take), .stored(stored), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   txp_tag_fifo #(.W(TAG_W), .DEPTH(STAT_DEPTH)) u_tags (
      .clk(clk), .rst_n(rst_n), .push(push), .din(tag_q), .pop(stat_pop),
      .dout(stat_tag), .empty(stat_empty), .level(stat_level), .drop(stat_full_irq)
   );

   assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> st_q == ST_CMDA);
   assert_irq_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_irq |-> st_q == ST_CMDA);
   assert_ovf_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_irq |-> ($stable(used_q) && $stable(st_q) && $stable(len_q)));
   assert_len_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
      len_q <= LEN_W'(FRAME_BYTES));
   assert_clr_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (st_q == ST_CMDA && used_q == '0));
   assert_used_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      used_q <= USED_W'(DFIFO_WORDS));
endmodule

// File: tb/txcmd_parser_test.sv
`timescale 1ns/1ps
module txcmd_parser_test;
   localparam int FB = 64, DW = 16, SD = 2;
   localparam int LW = $clog2(FB) + 1, AW = $clog2(FB), VW = $clog2(SD) + 1;
   localparam int NV = 23;

   logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, clr = 1'b0, stat_pop = 1'b0;
   logic [31:0] wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic frame_done, done_irq, ovf_irq, stat_full_irq, stat_empty;
   logic [LW-1:0] frame_len;
   logic [7:0] rd_data;
   logic [15:0] stat_tag;
   logic [VW-1:0] stat_level;
   int checks = 0, fails = 0, cyc = 0;

   always #2 clk = ~clk;

   txcmd_parser #(.FRAME_BYTES(FB), .DFIFO_WORDS(DW), .STAT_DEPTH(SD)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .clr(clr),
      .frame_done(frame_done), .frame_len(frame_len), .rd_addr(rd_addr),
      .rd_data(rd_data), .done_irq(done_irq), .ovf_irq(ovf_irq),
      .stat_full_irq(stat_full_irq), .stat_pop(stat_pop), .stat_tag(stat_tag),
      .stat_empty(stat_empty), .stat_level(stat_level)
   );

   // word, done, len, ioc, full
   localparam logic [41:0] VEC [NV] = '{
      {32'h00003005, 1'b0, 7'd0, 1'b0, 1'b0},
      {32'hAAAA0000, 1'b0, 7'd0, 1'b0, 1'b0},
      {32'h44332211, 1'b0, 7'd0, 1'b0, 1'b0},
      {32'hDDCCBB55, 1'b1, 7'd5, 1'b0, 1'b0},
      {32'h81063003, 1'b0, 7'd0, 1'b0, 1'b0},
      {32'hBEEF0000, 1'b0, 7'd0, 1'b0, 1'b0},
      {32'hFFFFFFFF, 1'b0, 7'd0, 1'b0, 1'b0},
      {32'h77665544, 1'b0, 7'd0, 1'b0, 1'b0},
      {32'h12345688, 1'b0, 7'd0, 1'b0, 1'b0},
      {32'h00000000, 1'b1, 7'd3, 1'b1, 1'b0},
      {32'h02002004, 1'b0, 7'd0, 1'b0, 1'b0},
      {32'hC0DE0000, 1'b0, 7'd0, 1'b0, 1'b0},
      {32'hD4C3B2A1, 1'b0, 7'd0, 1'b0, 1'b0},
      {32'h00000000, 1'b0, 7'd0, 1'b0, 1'b0},
      {32'h00000000, 1'b0, 7'd0, 1'b0, 1'b0},
      {32'h00000000, 1'b0, 7'd0, 1'b0, 1'b0},
      {32'h00000000, 1'b0, 7'd0, 1'b0, 1'b0},
      {32'h00000000, 1'b0, 7'd0, 1'b0, 1'b0},
      {32'h00000000, 1'b0, 7'd0, 1'b0, 1'b0},
      {32'h00000000, 1'b0, 7'd0, 1'b0, 1'b0},
      {32'h00001003, 1'b0, 7'd0, 1'b0, 1'b0},
      {32'h55550000, 1'b0, 7'd0, 1'b0, 1'b0},
      {32'h00F3F2F1, 1'b1, 7'd7, 1'b0, 1'b1}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic send(input logic [31:0] w);
      @(negedge clk);
      wr_en = 1'b1; wr_data = w;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse_clr();
      @(negedge clk); clr = 1'b1;
      @(posedge clk);
      @(negedge clk); clr = 1'b0;
   endtask

   task automatic pop_tag();
      @(negedge clk); stat_pop = 1'b1;
      @(posedge clk);
      @(negedge clk); stat_pop = 1'b0;
   endtask

   task automatic byte_at(input string req, input int a, input logic [7:0] exp);
      rd_addr = AW'(a);
      #1 check(req, {24'd0, rd_data}, {24'd0, exp});
   endtask

   task automatic finish_up();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 20000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected <20000 cycles", cyc);
            finish_up();
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", {27'd0, frame_done, done_irq, ovf_irq, stat_full_irq, stat_empty},
            32'h1);
      check("R1 level", 32'(stat_level), 32'd0);

      // Table: R2 R3 R4 R5 R6 R7 R8 R9 R13
      for (int i = 0; i < NV; i++) begin
         send(VEC[i][41:10]);
         if (VEC[i][9])
            check("R7 len", 32'(frame_len), 32'(VEC[i][8:2]));
         check("R7/R9/R8 flags", {29'd0, frame_done, done_irq, stat_full_irq},
               {29'd0, VEC[i][9], VEC[i][1], VEC[i][0]});
      end
      // R5 R13: multi-segment bytes, pad words not stored (R6)
      byte_at("R5", 0, 8'hA1); byte_at("R5", 1, 8'hB2);
      byte_at("R5", 2, 8'hC3); byte_at("R6", 3, 8'hD4);
      byte_at("R13", 4, 8'hF1); byte_at("R13", 5, 8'hF2);
      byte_at("R13", 6, 8'hF3);
      // R7 R8 status FIFO order, third tag dropped
      check("R8 level", 32'(stat_level), 32'd2);
      check("R7 tag", 32'(stat_tag), 32'h0000AAAA);
      pop_tag();
      check("R7 tag", 32'(stat_tag), 32'h0000BEEF);
      pop_tag();
      check("R8 empty", 32'(stat_empty), 32'd1);

      // R4 offset 1
      send(32'h00013004); send(32'h11110000); send(32'h33221100);
      send(32'h99999944);
      check("R4 done", {frame_done, 7'd0, frame_len}, {1'b1, 7'd0, 7'd4});
      byte_at("R4", 0, 8'h11); byte_at("R4", 1, 8'h22);
      byte_at("R4", 2, 8'h33); byte_at("R4", 3, 8'h44);

      // R10 overflow, R12 clear
      send(32'h0000203C); send(32'h22220000);
      for (int i = 0; i < 14; i++) send(32'h01010101 * (i + 1));
      check("R10 no early ovf", 32'(ovf_irq), 32'd0);
      send(32'hFFFFFFFF);
      check("R10 ovf", 32'(ovf_irq), 32'd1);
      pulse_clr();
      send(32'h00001001); send(32'h00000000); send(32'h000000EE);
      check("R12 done", {frame_done, 7'd0, frame_len}, {1'b1, 7'd0, 7'd57});
      byte_at("R10", 56, 8'hEE);
      check("R7 tag2", 32'(stat_tag), 32'h00001111);

      // R11 saturation
      send(32'h00002038); send(32'h33330000);
      for (int i = 0; i < 14; i++) send(32'h10101010 + i);
      pulse_clr();
      send(32'h0000100C); send(32'h00000000);
      send(32'h04030201); send(32'h5A6B7C8D); send(32'hEEEEEEEE);
      check("R11 len", {frame_done, 7'd0, frame_len}, {1'b1, 7'd0, 7'd64});
      byte_at("R11", 63, 8'h5A);

      // R12 priority of clr over a write
      @(negedge clk);
      clr = 1'b1; wr_en = 1'b1; wr_data = 32'h00003001;
      @(posedge clk);
      @(negedge clk);
      clr = 1'b0; wr_en = 1'b0;
      send(32'h00003001); send(32'h77770000);
      check("R12 not early", 32'(frame_done), 32'd0);
      send(32'h000000AB);
      check("R12 prio", {frame_done, 7'd0, frame_len}, {1'b1, 7'd0, 7'd1});
      byte_at("R12", 0, 8'hAB);
      finish_up();
   end
endmodule